// File: doc/BRIEF.md
# Header-Routed Packet Crossbar

This block is the switching core of an eight-port on-chip router. Each input accepts flits into a small FIFO. A packet is one header flit followed by zero or more payload flits, and its final flit carries a last marker. The header holds a 3-bit destination field, which picks the output, and a 3-bit source field, which names the input the packet entered on. The other header bits belong to the user.

Each output has its own arbiter. When the head of an input FIFO is a header, the destination field raises a request at that output. A free output grants the lowest-numbered requester and then stays bound to it until the flit marked last has gone through. The select index chosen by arbitration steers the crossbar lane. Each lane registers the forwarded flit and raises a data-available strobe to the next router for every cycle in which a valid flit is on the output. A blocked input keeps its data and its request until the output becomes free.

Top module: `xsw_switch`

## Requirements
- R1: The destination field of the header flit is bits [2:0] and selects the output port. The source field is bits [5:3]. Every flit, header included, leaves the switch with all of its data bits unchanged.
- R2: While `out_avail` of an output is high, `out_sel` of that output gives the index of the input that supplied the flit.
- R3: `out_avail` of an output is high in exactly the cycles that follow the removal of a flit for that output from an input FIFO. A header written at clock edge E is popped in the next cycle and is on the output after edge E+1.
- R4: `in_pop` of an input is high only when that input's FIFO is non-empty and the input holds an output grant.
- R5: An output is connected to at most one input at a time, and an input to at most one output. Packets that go to distinct outputs move in parallel.
- R6: An input whose destination is busy holds its flits and keeps requesting. It drops nothing. `in_ready` goes low while its FIFO (depth 4) is full.
- R7: A connection stays up until the flit marked last has been forwarded. Packets on one output are never interleaved, and the output can be granted again in the next cycle.
- R8: When several inputs wait for a free output, the lowest-numbered input is granted first.
- R9: During reset `out_avail` and `in_pop` are all low and `in_ready` is all high.
- R10: A single-flit packet, whose header carries the last marker, opens and closes its connection in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 8 | Per-input flit write strobe |
| in_data | input | 128 | Per-input flit data, 16 bits per port |
| in_last | input | 8 | Per-input last-flit marker |
| in_ready | output | 8 | Per-input FIFO not full |
| in_pop | output | 8 | Per-input FIFO read enable |
| out_avail | output | 8 | Per-output data-available strobe to the next router |
| out_data | output | 128 | Per-output flit data, 16 bits per port |
| out_last | output | 8 | Per-output last-flit marker |
| out_sel | output | 24 | Per-output index of the connected input, 3 bits per port |

## Verification
Some properties are checked on every cycle. No output has more than one granted input, and no input holds more than one grant. A read enable never fires on an empty FIFO or without a grant. A waiting non-empty FIFO never becomes empty without a pop. An output strobe always follows a pop routed to that output.

Other behaviour can only be shown by the bench's scenarios. These cover flit integrity and the source index, the order in which inputs win under contention, packets that are never interleaved, the exact cycle latency, stalls that fill a FIFO without losing data, and eight flows running at once.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
    localparam int ADDR_W  = 3;
    localparam int N_PORTS = 1 << ADDR_W;
    localparam int DST_LSB = 0;
    localparam int SRC_LSB = ADDR_W;
endpackage

// File: rtl/xsw_fifo.sv
module xsw_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t f_d, f_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (f_q.cnt == '0);
    assign full    = (f_q.cnt == CW'(DEPTH));
    assign rdata   = mem[f_q.rp];
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        f_d = f_q;
        if (push_ok) begin
            f_d.wp = (f_q.wp == AW'(DEPTH - 1)) ? '0 : f_q.wp + 1'b1;
        end
        if (pop_ok) begin
            f_d.rp = (f_q.rp == AW'(DEPTH - 1)) ? '0 : f_q.rp + 1'b1;
        end
        f_d.cnt = f_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[f_q.wp] <= wdata;
    end
endmodule

// File: rtl/xsw_out_arb.sv
module xsw_out_arb #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  pop_last,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] sel
);
    typedef struct packed {
        logic          locked;
        logic [IW-1:0] owner;
    } arb_st_t;

    arb_st_t a_d, a_q;
    logic [IW-1:0] win;
    logic          found;

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win   = IW'(i);
                found = 1'b1;
            end
        end
        gnt = '0;
        if (a_q.locked) begin
            sel            = a_q.owner;
            gnt[a_q.owner] = 1'b1;
        end else begin
            sel = win;
            if (found) gnt[win] = 1'b1;
        end
    end

    always_comb begin
        a_d = a_q;
        if (a_q.locked) begin
            if (pop_last[a_q.owner]) a_d.locked = 1'b0;
        end else if (found) begin
            a_d.owner  = win;
            a_d.locked = !pop_last[win];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end
endmodule

// File: rtl/xsw_xbar_lane.sv
module xsw_xbar_lane #(
    parameter int N  = 8,
    parameter int W  = 16,
    parameter int IW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   gnt,
    input  logic [IW-1:0]  sel,
    input  logic [N-1:0]   pop,
    input  logic [N*W-1:0] in_data,
    input  logic [N-1:0]   in_last,
    output logic [W-1:0]   out_data,
    output logic           out_last,
    output logic           out_avail,
    output logic [IW-1:0]  out_sel
);
    typedef struct packed {
        logic          avail;
        logic          last;
        logic [IW-1:0] src;
        logic [W-1:0]  data;
    } lane_st_t;

    lane_st_t l_d, l_q;

    always_comb begin
        l_d       = l_q;
        l_d.avail = |(gnt & pop);
        if (l_d.avail) begin
            l_d.data = in_data[int'(sel)*W +: W];
            l_d.last = in_last[sel];
            l_d.src  = sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign out_data  = l_q.data;
    assign out_last  = l_q.last;
    assign out_avail = l_q.avail;
    assign out_sel   = l_q.src;
endmodule

// File: rtl/xsw_switch.sv
module xsw_switch
    import xsw_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS*DATA_W-1:0]   in_data,
    input  logic [N_PORTS-1:0]          in_last,
    output logic [N_PORTS-1:0]          in_ready,
    output logic [N_PORTS-1:0]          in_pop,
    output logic [N_PORTS-1:0]          out_avail,
    output logic [N_PORTS*DATA_W-1:0]   out_data,
    output logic [N_PORTS-1:0]          out_last,
    output logic [N_PORTS*ADDR_W-1:0]   out_sel
);
    localparam int N  = N_PORTS;
    localparam int FW = DATA_W + 1;

    typedef struct packed {
        logic [N-1:0]             busy;
        logic [N-1:0][ADDR_W-1:0] dst;
    } port_st_t;

    port_st_t st_d, st_q;

    logic [N-1:0]        fifo_empty, fifo_full, head_last;
    logic [DATA_W-1:0]   head_data [N];
    logic [N*DATA_W-1:0] head_flat;
    logic [ADDR_W-1:0]   cur_dst [N];
    logic [N-1:0]        req_o [N];
    logic [N-1:0]        gnt_o [N];
    logic [ADDR_W-1:0]   arb_sel [N];
    logic [N-1:0]        granted, pop_last;
    logic [N*N-1:0]      gnt_all;

    generate
        for (genvar i = 0; i < N; i++) begin : g_in
            logic [FW-1:0] rd;
            xsw_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (in_valid[i]),
                .wdata ({in_last[i], in_data[i*DATA_W +: DATA_W]}),
                .pop   (in_pop[i]),
                .rdata (rd),
                .empty (fifo_empty[i]),
                .full  (fifo_full[i])
            );
            assign head_data[i] = rd[DATA_W-1:0];
            assign head_last[i] = rd[DATA_W];
            assign head_flat[i*DATA_W +: DATA_W] = rd[DATA_W-1:0];
        end
    endgenerate

    assign in_ready = ~fifo_full;

    // requests: a fresh header routes by its field, an open packet by the stored target
    always_comb begin
        for (int i = 0; i < N; i++) begin
            cur_dst[i] = st_q.busy[i] ? st_q.dst[i] : head_data[i][DST_LSB +: ADDR_W];
        end
        for (int o = 0; o < N; o++) begin
            for (int i = 0; i < N; i++) begin
                req_o[o][i] = !fifo_empty[i] && (cur_dst[i] == ADDR_W'(o));
            end
        end
    end

    always_comb begin
        granted = '0;
        for (int o = 0; o < N; o++) granted = granted | gnt_o[o];
        in_pop   = granted & ~fifo_empty;
        pop_last = in_pop & head_last;
        st_d     = st_q;
        for (int i = 0; i < N; i++) begin
            if (in_pop[i]) begin
                st_d.busy[i] = !head_last[i];
                st_d.dst[i]  = cur_dst[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar o = 0; o < N; o++) begin : g_out
            xsw_out_arb #(.N(N), .IW(ADDR_W)) u_arb (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (req_o[o]),
                .pop_last (pop_last),
                .gnt      (gnt_o[o]),
                .sel      (arb_sel[o])
            );
            xsw_xbar_lane #(.N(N), .W(DATA_W), .IW(ADDR_W)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .gnt       (gnt_o[o]),
                .sel       (arb_sel[o]),
                .pop       (in_pop),
                .in_data   (head_flat),
                .in_last   (head_last),
                .out_data  (out_data[o*DATA_W +: DATA_W]),
                .out_last  (out_last[o]),
                .out_avail (out_avail[o]),
                .out_sel   (out_sel[o*ADDR_W +: ADDR_W])
            );
            assign gnt_all[o*N +: N] = gnt_o[o];
        end
    endgenerate
endmodule

// File: rtl/xsw_checker.sv
module xsw_checker #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N*N-1:0] gnt_all,
    input logic [N-1:0]   in_pop,
    input logic [N-1:0]   fifo_empty,
    input logic [N-1:0]   out_avail
);
    logic [N-1:0] held_by [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int o = 0; o < N; o++) held_by[i][o] = gnt_all[o*N + i];
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_chk
            AST_OUT_SINGLE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(gnt_all[k*N +: N])); // R5
            AST_IN_SINGLE_DST: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(held_by[k]) <= 1); // R5
            AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                in_pop[k] |-> !fifo_empty[k]); // R4
            AST_POP_HAS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
                in_pop[k] |-> (held_by[k] != '0)); // R4
            AST_STALL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
                (!fifo_empty[k] && !in_pop[k]) |=> !fifo_empty[k]); // R6
            AST_AVAIL_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
                out_avail[k] |-> $past(|(gnt_all[k*N +: N] & in_pop))); // R3
        end
    endgenerate
endmodule

bind xsw_switch xsw_checker #(.N(xsw_pkg::N_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_all    (gnt_all),
    .in_pop     (in_pop),
    .fifo_empty (fifo_empty),
    .out_avail  (out_avail)
);

// File: tb/sim_xsw_switch.sv
module sim_xsw_switch;
    import xsw_pkg::*;
    localparam int W = 16;
    localparam int N = N_PORTS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [W-1:0]   drv_d [N];
    logic [N-1:0]   drv_v, drv_l;
    logic [N*W-1:0] in_data;
    logic [N-1:0]   in_ready, in_pop, out_avail, out_last;
    logic [N*W-1:0] out_data;
    logic [N*3-1:0] out_sel;

    always_comb for (int i = 0; i < N; i++) in_data[i*W +: W] = drv_d[i];

    xsw_switch u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(drv_v), .in_data(in_data), .in_last(drv_l),
        .in_ready(in_ready), .in_pop(in_pop), .out_avail(out_avail), .out_data(out_data),
        .out_last(out_last), .out_sel(out_sel)
    );

    int checks = 0, fails = 0, mchecks = 0, mfails = 0;
    logic [19:0] exp_q [N][$];
    bit mon_en = 0, contend = 0, seen_stall7 = 0, seen_all = 0, wd = 0;

    function automatic logic [W-1:0] mk_flit(int s, int d, int k, int tag);
        if (k == 0) return {tag[9:0], 3'(s), 3'(d)};
        return W'(s*4099 + d*257 + k*31 + tag*7);
    endfunction

    task automatic expect_pkt(int s, int d, int len, int tag);
        for (int k = 0; k < len; k++)
            exp_q[d].push_back({3'(s), (k == len-1), mk_flit(s, d, k, tag)});
    endtask

    task automatic send(int i, int d, int len, int tag);
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            drv_v[i] = 1'b1;
            drv_d[i] = mk_flit(i, d, k, tag);
            drv_l[i] = (k == len-1);
            while (!in_ready[i]) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        drv_v[i] = 1'b0;
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drain(string req);
        int left;
        for (int c = 0; c < 400; c++) begin
            left = 0;
            for (int o = 0; o < N; o++) left += exp_q[o].size();
            if (left == 0) break;
            @(negedge clk);
        end
        left = 0;
        for (int o = 0; o < N; o++) left += exp_q[o].size();
        chk(req, "flits still expected", left, 0);
    endtask

    // output monitor: every strobed flit must match the expected stream of that output
    always @(negedge clk) begin
        if (mon_en) begin
            for (int o = 0; o < N; o++) begin
                if (out_avail[o]) begin
                    mchecks++;
                    if (exp_q[o].size() == 0) begin
                        mfails++;
                        $display("FAIL R3 out%0d unexpected flit: got %h expected none", o, out_data[o*W +: W]);
                    end else begin
                        logic [19:0] e;
                        e = exp_q[o].pop_front();
                        if ({out_sel[o*3 +: 3], out_last[o], out_data[o*W +: W]} !== e) begin
                            mfails++;
                            $display("FAIL R1/R2/R7/R8 out%0d: got %h expected %h", o,
                                     {out_sel[o*3 +: 3], out_last[o], out_data[o*W +: W]}, e);
                        end
                    end
                end
            end
            if (contend) begin
                mchecks++;
                if ($countones(in_pop) > 1) begin
                    mfails++;
                    $display("FAIL R5 pops on shared output: got %0d expected <=1", $countones(in_pop));
                end
            end
            if (drv_v[7] && !in_ready[7]) seen_stall7 = 1;
            if (&out_avail) seen_all = 1;
        end
    end

    initial begin
        drv_v = '0;
        drv_l = '0;
        for (int i = 0; i < N; i++) drv_d[i] = '0;
        fork
            begin
                repeat (3) @(negedge clk);
                // R9 reset state
                chk("R9", "out_avail in reset", out_avail, 0);
                chk("R9", "in_ready in reset", in_ready, 8'hFF);
                chk("R9", "in_pop in reset", in_pop, 0);
                rst_n = 1'b1;
                mon_en = 1;
                @(negedge clk);

                // R3 latency, R4 pop timing, R1/R2 header integrity
                expect_pkt(2, 5, 2, 77);
                drv_v[2] = 1'b1; drv_d[2] = mk_flit(2, 5, 0, 77); drv_l[2] = 1'b0;
                @(negedge clk);
                chk("R4", "pop of input 2 one cycle after write", in_pop, 8'h04);
                chk("R3", "no output yet", out_avail, 0);
                drv_d[2] = mk_flit(2, 5, 1, 77); drv_l[2] = 1'b1;
                @(negedge clk);
                drv_v[2] = 1'b0;
                chk("R3", "header strobe on out5", out_avail, 8'h20);
                chk("R1", "header bits unchanged", out_data[5*W +: W], mk_flit(2, 5, 0, 77));
                chk("R2", "select index", out_sel[5*3 +: 3], 2);
                @(negedge clk);
                chk("R7", "last flit marker", out_last[5], 1);
                @(negedge clk);
                chk("R3", "strobe drops when no data", out_avail, 0);

                // R1 / R10 full sweep of source x destination, lengths 1..4
                for (int s = 0; s < N; s++)
                    for (int d = 0; d < N; d++) begin
                        expect_pkt(s, d, 1 + (s + d) % 4, s*8 + d);
                        send(s, d, 1 + (s + d) % 4, s*8 + d);
                    end
                drain("R1");

                // R6 / R8 all inputs contend for output 3, packets longer than the FIFO
                contend = 1;
                for (int i = 0; i < N; i++) expect_pkt(i, 3, 5, 100 + i);
                for (int i = 0; i < N; i++) begin
                    automatic int ii = i;
                    fork send(ii, 3, 5, 100 + ii); join_none
                end
                wait fork;
                drain("R8");
                contend = 0;
                chk("R6", "input 7 saw a full FIFO", seen_stall7, 1);

                // R5 rotations: all eight flows in parallel
                for (int k = 1; k < N; k++) begin
                    for (int i = 0; i < N; i++) expect_pkt(i, (i + k) % N, 3, 200 + k*8 + i);
                    for (int i = 0; i < N; i++) begin
                        automatic int ii = i;
                        automatic int kk = k;
                        fork send(ii, (ii + kk) % N, 3, 200 + kk*8 + ii); join_none
                    end
                    wait fork;
                    drain("R5");
                end
                chk("R5", "all outputs active together", seen_all, 1);

                // R10 / R7 back-to-back packets from one input, including a single-flit one
                expect_pkt(4, 1, 2, 300);
                expect_pkt(4, 6, 1, 301);
                expect_pkt(4, 1, 3, 302);
                send(4, 1, 2, 300);
                send(4, 6, 1, 301);
                send(4, 1, 3, 302);
                drain("R10");
                @(negedge clk);
                chk("R9", "idle after traffic", out_avail, 0);
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        if (wd) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        checks += mchecks;
        fails += mfails;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule